// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block collects interrupt events from peripherals and presents them to up to four processors (sixteen at the most) as a 4-bit request level for each processor. Peripherals raise one of the levels 1 to 15 with a single-cycle pulse. A broadcast register picks, level by level, where the event goes. It can go to one shared pending register, which is visible to every processor. It can instead go to a private force register that every processor has. Each processor has its own mask, and the unmasked request with the highest number is what it sees.

A processor acknowledges a level by pulsing its acknowledge valid together with the level number. The block clears that processor's own force bit when it is set. Otherwise it clears the shared pending bit. The block also keeps a power-down flag for each processor. The processor sets the flag with a pulse, and software clears it through the status register to wake that processor. All state can be reached through a simple APB-style register port with 12-bit byte addresses.

Top module: `mpic_top`

## Requirements
- R1: For each processor c, the request vector is (pending OR force[c]) AND mask[c], and bit 0 is always excluded. A level that is pending or forced but masked, and level 0, never appears on that processor's request output.
- R2: irl[4c+3:4c] carries the number of the highest set bit of processor c's request vector, and 0 when no bit is set. The output is registered, so it follows a change in pending, force or mask one clock later.
- R3: An irq_pulse bit L (1..15) sampled high sets force bit L of every processor when bit L of the broadcast register (offset 0x214) is 1. When that broadcast bit is 0, it sets bit L of the shared pending register instead.
- R4: ack_valid[c] with ack_level[4c+3:4c]=L clears processor c's force bit L if that bit is set. Otherwise it clears pending bit L. Other processors' force bits are left alone.
- R5: Reset (rst_n low) clears pending, broadcast, every mask, every force register, every power-down flag and every request output.
- R6: Reading the status register at offset 0x210 returns NUM_CPU-1 in bits 31:28 and processor i's power-down flag in bit i. All other bits read 0.
- R7: A pwd_enter[i] pulse sets power-down flag i. Writing the status register clears flag i for every data bit i written as 1. Bits written as 0 leave their flags unchanged.
- R8: Writing offset 0x20C clears each pending bit whose data bit is 1, and leaves the other pending bits unchanged. The offset itself reads 0.
- R9: The register map is: pending at 0x204 (read/write), processor c's mask at 0x240+4c, and processor c's force at 0x280+4c. Offset 0x208 is a second address for processor 0's force register. Bit 0 and bits 31:16 of these registers always read 0, and any unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register port select |
| reg_en | input | 1 | Register port access phase; a write takes effect on the edge where sel, en and write are all high |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_sel is high with reg_write low |
| irq_pulse | input | 16 | One bit per level; a high bit for one cycle raises that level; bit 0 is ignored |
| ack_valid | input | NUM_CPU | Acknowledge strobe, one bit per processor |
| ack_level | input | 4*NUM_CPU | Acknowledged level, 4 bits per processor |
| pwd_enter | input | NUM_CPU | Power-down entry pulse, one bit per processor |
| irl | output | 4*NUM_CPU | Registered request level, 4 bits per processor |

## Verification
The bench checks that an acknowledge picks the correct register. If a broadcast level is still forced for one processor, a design that cleared the shared pending bit instead would drop another processor's request, or would leave the acknowledged level stuck on that processor. The bench also checks masking of forced levels. A design that masked only the pending register would show a forced level to a processor whose mask excludes it. Further checks cover the force alias at 0x208, level 0 being ignored at both the pulse input and the mask register, and status writes with zero bits. A design that toggled flags or cleared all of them would report the wrong sleeping processors. The final check asserts reset in the middle of the run, after every register has been loaded.

// File: rtl/mpic_pkg.sv
// Shared constants, types and helpers of the multiprocessor interrupt
// controller. Assumes 16 levels (0 unused) and a 12-bit byte address space.
package mpic_pkg;
    localparam int LVL_N  = 16;
    localparam int LVL_W  = $clog2(LVL_N);
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    typedef logic [LVL_N-1:0] lvl_vec_t;

    // Levels that can actually request; level 0 is never usable.
    localparam lvl_vec_t LVL_USABLE = {{(LVL_N-1){1'b1}}, 1'b0};

    localparam logic [ADDR_W-1:0] OFS_PEND       = 12'h204;
    localparam logic [ADDR_W-1:0] OFS_FORCE0     = 12'h208;
    localparam logic [ADDR_W-1:0] OFS_CLEAR      = 12'h20C;
    localparam logic [ADDR_W-1:0] OFS_STATUS     = 12'h210;
    localparam logic [ADDR_W-1:0] OFS_BCAST      = 12'h214;
    localparam logic [ADDR_W-1:0] OFS_MASK_BASE  = 12'h240;
    localparam logic [ADDR_W-1:0] OFS_FORCE_BASE = 12'h280;

    // One-hot vector for a level number, with level 0 removed.
    function automatic lvl_vec_t lvl_decode(input logic [LVL_W-1:0] lvl);
        lvl_vec_t v;
        v = '0;
        v[lvl] = 1'b1;
        return v & LVL_USABLE;
    endfunction
endpackage

// File: rtl/mpic_prio_enc.sv
// Priority encoder: returns the index of the highest set bit of the
// request vector, or 0 when no bit is set. Bit 0 is not considered.
module mpic_prio_enc
    import mpic_pkg::*;
(
    input  lvl_vec_t         req,
    output logic [LVL_W-1:0] lvl
);
    // Scan upward so that the last hit is the highest level.
    always_comb begin
        lvl = '0;
        for (int i = 1; i < LVL_N; i++) begin
            if (req[i]) lvl = LVL_W'(i);
        end
    end
endmodule

// File: rtl/mpic_pending.sv
// Shared pending register. The order inside one cycle is: register write,
// then clears (clear register and acknowledges), then new raises. A raise
// therefore wins over a clear of the same level in the same cycle.
module mpic_pending
    import mpic_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  lvl_vec_t wr_val,
    input  lvl_vec_t clr_bits,
    input  lvl_vec_t set_bits,
    output lvl_vec_t pend_q
);
    // Update the pending register each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (((wr_en ? wr_val : pend_q) & ~clr_bits) | set_bits) & LVL_USABLE;
    end
endmodule

// File: rtl/mpic_cpu_slice.sv
// Per-processor state: mask, force register and the registered request
// level. The slice also works out whether this processor's acknowledge
// has to clear the shared pending bit (only when its force bit is clear).
module mpic_cpu_slice
    import mpic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_wr,
    input  logic             force_wr,
    input  lvl_vec_t         wr_val,
    input  lvl_vec_t         pend_q,
    input  lvl_vec_t         raise_bcast,
    input  logic             ack_valid,
    input  logic [LVL_W-1:0] ack_level,
    output lvl_vec_t         mask_q,
    output lvl_vec_t         force_q,
    output lvl_vec_t         pend_clr,
    output logic [LVL_W-1:0] irl_q
);
    lvl_vec_t         ack_vec;
    lvl_vec_t         force_hit;
    lvl_vec_t         eff;
    logic [LVL_W-1:0] irl_nxt;

    // Split the acknowledge between the force and the pending register.
    always_comb begin
        ack_vec   = ack_valid ? lvl_decode(ack_level) : '0;
        force_hit = ack_vec & force_q;
        pend_clr  = ack_vec & ~force_q;
        eff       = (pend_q | force_q) & mask_q & LVL_USABLE;
    end

    mpic_prio_enc prio_i (.req(eff), .lvl(irl_nxt));

    // Mask register, written only from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wr_val & LVL_USABLE;
    end

    // Force register: write, then acknowledge clear, then broadcast raise.
    always_ff @(posedge clk) begin
        if (!rst_n) force_q <= '0;
        else        force_q <= (((force_wr ? wr_val : force_q) & ~force_hit) | raise_bcast) & LVL_USABLE;
    end

    // Registered request level toward the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) irl_q <= '0;
        else        irl_q <= irl_nxt;
    end
endmodule

// File: rtl/mpic_top.sv
// Multiprocessor interrupt controller top. It decodes the register port,
// routes peripheral pulses to the pending or the force registers, and keeps
// the power-down flags. Assumes NUM_CPU <= 16 (status bits 31:28).
module mpic_top
    import mpic_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_sel,
    input  logic                     reg_en,
    input  logic                     reg_write,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic [LVL_N-1:0]         irq_pulse,
    input  logic [NUM_CPU-1:0]       ack_valid,
    input  logic [NUM_CPU*LVL_W-1:0] ack_level,
    input  logic [NUM_CPU-1:0]       pwd_enter,
    output logic [NUM_CPU*LVL_W-1:0] irl
);
    localparam logic [3:0] CPU_CNT_M1 = 4'(NUM_CPU - 1);

    logic                    wr_go;
    lvl_vec_t                wr_val;
    lvl_vec_t                raise;
    lvl_vec_t                bcast_q;
    lvl_vec_t                pend_q;
    lvl_vec_t                clr_all;
    logic [NUM_CPU-1:0]      pwd_q;
    lvl_vec_t [NUM_CPU-1:0]  mask_vec;
    lvl_vec_t [NUM_CPU-1:0]  force_vec;
    lvl_vec_t [NUM_CPU-1:0]  clr_vec;

    // Write strobe and the level-sized part of the write data.
    always_comb begin
        wr_go  = reg_sel & reg_en & reg_write;
        wr_val = reg_wdata[LVL_N-1:0] & LVL_USABLE;
        raise  = irq_pulse & LVL_USABLE;
    end

    // Combine the clear register with every processor's pending clear.
    always_comb begin
        clr_all = (wr_go && reg_addr == OFS_CLEAR) ? wr_val : '0;
        for (int c = 0; c < NUM_CPU; c++) clr_all |= clr_vec[c];
    end

    // Broadcast selection register.
    always_ff @(posedge clk) begin
        if (!rst_n)                              bcast_q <= '0;
        else if (wr_go && reg_addr == OFS_BCAST) bcast_q <= wr_val;
    end

    // Power-down flags: status write clears first, then an entry pulse sets.
    always_ff @(posedge clk) begin
        if (!rst_n) pwd_q <= '0;
        else        pwd_q <= (pwd_q & ~((wr_go && reg_addr == OFS_STATUS) ?
                                        reg_wdata[NUM_CPU-1:0] : '0)) | pwd_enter;
    end

    mpic_pending pend_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_go && reg_addr == OFS_PEND),
        .wr_val   (wr_val),
        .clr_bits (clr_all),
        .set_bits (raise & ~bcast_q),
        .pend_q   (pend_q)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        localparam logic [ADDR_W-1:0] MASK_AD  = OFS_MASK_BASE + ADDR_W'(4 * c);
        localparam logic [ADDR_W-1:0] FORCE_AD = OFS_FORCE_BASE + ADDR_W'(4 * c);
        logic force_sel;

        // Processor 0's force register also answers at the alias offset.
        always_comb force_sel = (reg_addr == FORCE_AD) || (c == 0 && reg_addr == OFS_FORCE0);

        mpic_cpu_slice slice_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .mask_wr     (wr_go && reg_addr == MASK_AD),
            .force_wr    (wr_go && force_sel),
            .wr_val      (wr_val),
            .pend_q      (pend_q),
            .raise_bcast (raise & bcast_q),
            .ack_valid   (ack_valid[c]),
            .ack_level   (ack_level[c*LVL_W +: LVL_W]),
            .mask_q      (mask_vec[c]),
            .force_q     (force_vec[c]),
            .pend_clr    (clr_vec[c]),
            .irl_q       (irl[c*LVL_W +: LVL_W])
        );
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_sel && !reg_write) begin
            case (reg_addr)
                OFS_PEND:   reg_rdata[LVL_N-1:0] = pend_q;
                OFS_FORCE0: reg_rdata[LVL_N-1:0] = force_vec[0];
                OFS_BCAST:  reg_rdata[LVL_N-1:0] = bcast_q;
                OFS_STATUS: begin
                    reg_rdata[DATA_W-1 -: 4] = CPU_CNT_M1;
                    reg_rdata[NUM_CPU-1:0]   = pwd_q;
                end
                default: ;
            endcase
            for (int c = 0; c < NUM_CPU; c++) begin
                if (reg_addr == OFS_MASK_BASE + ADDR_W'(4 * c))
                    reg_rdata[LVL_N-1:0] = mask_vec[c];
                if (reg_addr == OFS_FORCE_BASE + ADDR_W'(4 * c))
                    reg_rdata[LVL_N-1:0] = force_vec[c];
            end
        end
    end
endmodule

// File: rtl/mpic_chk.sv
// Assertion checker for mpic_top, attached by bind. It watches processor 0's
// slice, the shared pending register and the power-down flags.
module mpic_chk
    import mpic_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_sel,
    input logic               reg_en,
    input logic               reg_write,
    input logic [LVL_N-1:0]   irq_pulse,
    input logic               ack_valid0,
    input logic [LVL_W-1:0]   ack_lvl0,
    input logic [NUM_CPU-1:0] pwd_enter,
    input logic [NUM_CPU-1:0] pwd_q,
    input lvl_vec_t           bcast_q,
    input lvl_vec_t           pend_q,
    input lvl_vec_t           force0,
    input lvl_vec_t           mask0,
    input logic [LVL_W-1:0]   irl0
);
    lvl_vec_t eff0;
    lvl_vec_t hit_b;
    lvl_vec_t hit_p;
    logic     wr_any;

    // Observed request vector of processor 0 and the raises per destination.
    always_comb begin
        eff0   = (pend_q | force0) & mask0 & LVL_USABLE;
        hit_b  = irq_pulse & bcast_q & LVL_USABLE;
        hit_p  = irq_pulse & ~bcast_q & LVL_USABLE;
        wr_any = reg_sel & reg_en & reg_write;
    end

    AST_IRL_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (irl0 == '0) |-> ($past(eff0) == '0));                              // R1

    AST_IRL_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (irl0 != '0) |-> (($past(eff0) >> irl0) == lvl_vec_t'(1)));         // R2

    AST_BCAST_TO_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_b != '0) |=> ((force0 & $past(hit_b)) == $past(hit_b)));       // R3

    AST_SHARED_TO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_p != '0) |=> ((pend_q & $past(hit_p)) == $past(hit_p)));       // R3

    AST_ACK_FORCE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid0 && ack_lvl0 != '0 && force0[ack_lvl0] && !irq_pulse[ack_lvl0] && !wr_any)
        |=> !force0[$past(ack_lvl0)]);                                      // R4

    AST_PWD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (pwd_enter != '0) |=> ((pwd_q & $past(pwd_enter)) == $past(pwd_enter))); // R7
endmodule

bind mpic_top mpic_chk #(.NUM_CPU(NUM_CPU)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .reg_en     (reg_en),
    .reg_write  (reg_write),
    .irq_pulse  (irq_pulse),
    .ack_valid0 (ack_valid[0]),
    .ack_lvl0   (ack_level[3:0]),
    .pwd_enter  (pwd_enter),
    .pwd_q      (pwd_q),
    .bcast_q    (bcast_q),
    .pend_q     (pend_q),
    .force0     (force_vec[0]),
    .mask0      (mask_vec[0]),
    .irl0       (irl[3:0])
);

// File: tb/mpic_top_tb_top.sv
// Directed bench for mpic_top: one task per scenario, each checking itself.
module mpic_top_tb_top;
    localparam int NCPU = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_sel = 1'b0, reg_en = 1'b0, reg_write = 1'b0;
    logic [11:0]       reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [15:0]       irq_pulse = '0;
    logic [NCPU-1:0]   ack_valid = '0;
    logic [NCPU*4-1:0] ack_level = '0;
    logic [NCPU-1:0]   pwd_enter = '0;
    logic [NCPU*4-1:0] irl;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    mpic_top #(.NUM_CPU(NCPU)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_en(reg_en),
        .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_pulse(irq_pulse), .ack_valid(ack_valid),
        .ack_level(ack_level), .pwd_enter(pwd_enter), .irl(irl)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); reg_sel = 1; reg_write = 1; reg_addr = a; reg_wdata = d; reg_en = 0;
        @(negedge clk); reg_en = 1;
        @(negedge clk); reg_sel = 0; reg_en = 0; reg_write = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); reg_sel = 1; reg_write = 0; reg_addr = a; reg_en = 0;
        @(negedge clk); reg_en = 1; #1 d = reg_rdata;
        @(negedge clk); reg_sel = 0; reg_en = 0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic pulse(input logic [15:0] v);
        @(negedge clk); irq_pulse = v;
        @(negedge clk); irq_pulse = '0;
    endtask

    task automatic ack(input int c, input logic [3:0] l);
        @(negedge clk); ack_valid[c] = 1'b1; ack_level[c*4 +: 4] = l;
        @(negedge clk); ack_valid[c] = 1'b0; ack_level[c*4 +: 4] = '0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_irl(input string req, input int c, input logic [3:0] exp);
        chk(req, 32'(irl[c*4 +: 4]), 32'(exp));
    endtask

    task automatic t_reset_state();
        for (int c = 0; c < NCPU; c++) chk_irl("R5 irl after reset", c, 4'd0);
        rd_chk("R5 pending after reset", 12'h204, 32'h0);
        rd_chk("R5 mask0 after reset", 12'h240, 32'h0);
        rd_chk("R6 status after reset", 12'h210, 32'h3000_0000);
    endtask

    task automatic t_shared_route();
        wr(12'h240, 32'h0000_FFFE);
        wr(12'h244, 32'h0000_0010);
        pulse(16'h0010);
        settle();
        rd_chk("R3 shared level 4 in pending", 12'h204, 32'h0000_0010);
        chk_irl("R1 cpu0 sees level 4", 0, 4'd4);
        chk_irl("R1 cpu1 sees level 4", 1, 4'd4);
        chk_irl("R1 cpu2 masked", 2, 4'd0);
    endtask

    task automatic t_priority();
        pulse(16'h0200);
        settle();
        chk_irl("R2 cpu0 highest is 9", 0, 4'd9);
        chk_irl("R2 cpu1 mask keeps 4", 1, 4'd4);
        ack(0, 4'd9);
        settle();
        rd_chk("R4 ack 9 clears pending", 12'h204, 32'h0000_0010);
        chk_irl("R2 cpu0 falls to 4", 0, 4'd4);
    endtask

    task automatic t_broadcast();
        wr(12'h214, 32'h0000_1000);
        rd_chk("R3 broadcast readback", 12'h214, 32'h0000_1000);
        pulse(16'h1000);
        settle();
        rd_chk("R3 force cpu0", 12'h280, 32'h0000_1000);
        rd_chk("R3 force cpu3", 12'h28C, 32'h0000_1000);
        rd_chk("R3 pending untouched", 12'h204, 32'h0000_0010);
        chk_irl("R2 cpu0 at 12", 0, 4'd12);
        ack(0, 4'd12);
        settle();
        rd_chk("R4 ack clears own force", 12'h280, 32'h0);
        rd_chk("R4 other force kept", 12'h284, 32'h0000_1000);
        rd_chk("R4 pending kept when force hit", 12'h204, 32'h0000_0010);
        ack(0, 4'd4);
        settle();
        rd_chk("R4 ack w/o force clears pending", 12'h204, 32'h0);
        chk_irl("R1 cpu1 forced 12 masked", 1, 4'd0);
        chk_irl("R2 cpu0 idle", 0, 4'd0);
    endtask

    task automatic t_level_zero();
        wr(12'h240, 32'hFFFF_FFFF);
        rd_chk("R9 mask bit0/upper read 0", 12'h240, 32'h0000_FFFE);
        pulse(16'h0001);
        settle();
        rd_chk("R1 level 0 pulse ignored", 12'h204, 32'h0);
        chk_irl("R1 level 0 never requested", 0, 4'd0);
    endtask

    task automatic t_clear_reg();
        pulse(16'h00A0);
        settle();
        rd_chk("R3 two levels pending", 12'h204, 32'h0000_00A0);
        chk_irl("R2 cpu0 at 7", 0, 4'd7);
        wr(12'h20C, 32'h0000_0080);
        settle();
        rd_chk("R8 clear only bit 7", 12'h204, 32'h0000_0020);
        rd_chk("R8 clear offset reads 0", 12'h20C, 32'h0);
        chk_irl("R2 cpu0 at 5", 0, 4'd5);
    endtask

    task automatic t_power_down();
        @(negedge clk); pwd_enter = 4'b1010;
        @(negedge clk); pwd_enter = '0;
        rd_chk("R6 status flags 1 and 3", 12'h210, 32'h3000_000A);
        wr(12'h210, 32'h0000_0002);
        rd_chk("R7 write 1 wakes cpu1", 12'h210, 32'h3000_0008);
        wr(12'h210, 32'h0000_0000);
        rd_chk("R7 write 0 no effect", 12'h210, 32'h3000_0008);
    endtask

    task automatic t_map();
        wr(12'h208, 32'h0000_0400);
        rd_chk("R9 alias writes cpu0 force", 12'h280, 32'h0000_0400);
        rd_chk("R9 alias readback", 12'h208, 32'h0000_0400);
        settle();
        chk_irl("R1 forced 10 on cpu0", 0, 4'd10);
        rd_chk("R9 unmapped 0x250", 12'h250, 32'h0);
        rd_chk("R9 unmapped 0x100", 12'h100, 32'h0);
        wr(12'h204, 32'h0000_8001);
        rd_chk("R9 pending write", 12'h204, 32'h0000_8000);
        settle();
        chk_irl("R2 cpu0 at 15", 0, 4'd15);
    endtask

    task automatic t_mid_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < NCPU; c++) chk_irl("R5 irl cleared", c, 4'd0);
        rd_chk("R5 pending cleared", 12'h204, 32'h0);
        rd_chk("R5 mask cleared", 12'h240, 32'h0);
        rd_chk("R5 force cleared", 12'h280, 32'h0);
        rd_chk("R5 broadcast cleared", 12'h214, 32'h0);
        rd_chk("R5 power-down cleared", 12'h210, 32'h3000_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_shared_route();
        t_priority();
        t_broadcast();
        t_level_zero();
        t_clear_reg();
        t_power_down();
        t_map();
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R1-watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule